// File: doc/BRIEF.md
# Synchronous Serial Master Port

This block is a memory-mapped master for a four-wire synchronous serial link using the common clock-polarity/clock-phase framing. Software pushes words of 4 to 16 bits into an 8-entry transmit queue through a data register. The port sends each word most significant bit first and collects the word that arrives on the input line during the same frame. That word goes into an 8-entry receive queue, and software pops it by reading the same data register. Each frame sent therefore yields exactly one frame received, so software can track the number of words in flight by counting pushes against pops.

The serial clock timing comes from an external bit-rate generator. This block hands that generator its prescale value and rate divider, and it receives back a `half_tick` pulse for each half period of the serial clock. Frames advance only on that pulse.

A three-state shifter runs the frames:
- SH_IDLE: waiting, with the clock at rest.
- SH_LEAD: first half of a bit, with the clock at its rest level.
- SH_TRAIL: second half of a bit, after the leading edge.

The shifter makes these transitions:
- start: SH_IDLE to SH_LEAD, on a tick while the port is enabled and a word is queued.
- lead edge: SH_LEAD to SH_TRAIL, on a tick.
- next bit: SH_TRAIL to SH_LEAD, on a tick while bits remain.
- frame end: SH_TRAIL to SH_IDLE, on the tick of the last bit's trailing edge.
- halt: any state to SH_IDLE, when the port is disabled.

Interrupt lines report a receive queue at least half full, a transmit queue at most half full, and a receive overrun.

Top module: `ssp_master`

## Requirements
- R1: After reset, the status register reads 0x03, `sclk` and `mosi` are 0, and all three interrupt outputs are 0.
- R2: The registers are addressed by byte offset.
  - 0x00 is the format register: bits 3:0 hold the word length minus one, bit 6 is clock polarity, bit 7 is clock phase, and bits 15:8 are the rate divider. Bits 5:4 read 0.
  - 0x04 is the control register: bit 0 is receive interrupt enable, bit 1 transmit interrupt enable, bit 2 overrun interrupt enable, bit 3 loopback, bit 4 port enable, bit 5 slave select (stored only), and bit 6 output disable (stored only).
  - 0x10 is the 8-bit prescale register.
  - The rate divider and the prescale value are also driven on `rate_div` and `rate_prescale`.
- R3: Each frame shifts out N = length field + 1 bits of the queued word, most significant bit first.
  - Phase 0: each bit is presented before the leading edge and advances on the trailing edge.
  - Phase 1: each bit changes on the leading edge.
- R4: The port captures one N-bit word from `miso` per frame: on the leading edge with phase 0, on the trailing edge with phase 1. Reading offset 0x08 pops the oldest received word, zero-extended.
- R5: With loopback set, the received word equals the transmitted word and `miso` has no effect.
- R6: The status register at 0x0C reports five flags: bit 0 transmit queue empty, bit 1 transmit queue not full, bit 2 receive queue not empty, bit 3 receive queue full, and bit 4 busy (a frame in progress or a word queued).
- R7: Each queue holds 8 words. A write to 0x08 when the transmit queue is full is dropped. A read of 0x08 when the receive queue is empty returns 0.
- R8: A frame that ends while the receive queue is full is discarded and sets the overrun flag. The flag is reported in bit 2 of offset 0x14 and on `irq_ror` when its enable bit is set.
- R9: Any write to offset 0x14 clears the overrun flag.
- R10: `irq_rx` is high when the receive queue holds at least 4 words and its enable is set. `irq_tx` is high when the transmit queue holds at most 4 words and its enable is set. Offset 0x14 reads the receive interrupt in bit 0 and the transmit interrupt in bit 1.
- R11: While the port is disabled, both queues are held empty and the shifter stays idle.
- R12: While no frame runs, and whenever the port is disabled, `sclk` rests at the polarity bit. During a frame, `sclk` changes only on a `half_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| half_tick | input | 1 | Half-bit pulse from the rate generator |
| rate_prescale | output | 8 | Prescale value for the rate generator |
| rate_div | output | 8 | Rate divider for the rate generator |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |
| irq_ror | output | 1 | Receive overrun interrupt |

## Verification
Frames are run in all four polarity/phase modes, with random word lengths from 4 to 16 bits and random tick spacing. A bench slave drives independent random words, so a wrong sampling edge or bit order shows up as a mismatch on either data line. Loopback runs use a slave that drives data different from the transmitted words, which separates the internal return path from the external pin. Directed sequences fill the queues with the tick stopped and then let them drain. These runs separate the half-full interrupt thresholds, the dropped ninth write, the discarded overrun frame and its clear, and the flush on disable.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
package ssp_pkg;

    // Shifter phases
    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_LEAD  = 2'd1,
        SH_TRAIL = 2'd2
    } sh_state_t;

    // Word index of each register (byte offset / 4)
    localparam logic [2:0] ADR_FMT   = 3'd0;
    localparam logic [2:0] ADR_CTL   = 3'd1;
    localparam logic [2:0] ADR_DATA  = 3'd2;
    localparam logic [2:0] ADR_STAT  = 3'd3;
    localparam logic [2:0] ADR_PRESC = 3'd4;
    localparam logic [2:0] ADR_IRQ   = 3'd5;

endpackage

// File: rtl/ssp_fifo.sv
`timescale 1ns/1ps
module ssp_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = mem[rp];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else if (flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

endmodule

// File: rtl/ssp_shifter.sv
`timescale 1ns/1ps
module ssp_shifter
    import ssp_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int IW    = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [IW-1:0]     len_m1,
    input  logic              loop,
    input  logic              miso,
    input  logic              tx_avail,
    input  logic [DATA_W-1:0] tx_word,
    output logic              tx_take,
    output logic              sclk,
    output logic              mosi,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_word,
    output logic              busy
);
    sh_state_t         state, nxt;
    logic [DATA_W-1:0] word_q, rx_sr;
    logic [IW-1:0]     idx;
    logic              first_q, din;

    assign tx_take  = (state == SH_IDLE) && en && tick && tx_avail;
    assign rx_valid = (state == SH_TRAIL) && en && tick && (idx == '0);
    assign mosi     = (state == SH_IDLE) ? 1'b0 : word_q[idx];
    assign din      = loop ? mosi : miso;
    assign busy     = (state != SH_IDLE);
    // with phase 1 the last bit is captured on the same edge that ends the frame
    assign rx_word  = cpha ? {rx_sr[DATA_W-2:0], din} : rx_sr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SH_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            SH_IDLE:  if (tx_take) nxt = SH_LEAD;
            SH_LEAD:  if (tick)    nxt = SH_TRAIL;
            SH_TRAIL: if (tick)    nxt = (idx == '0) ? SH_IDLE : SH_LEAD;
            default:               nxt = SH_IDLE;
        endcase
        if (!en) nxt = SH_IDLE;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk    <= 1'b0;
            word_q  <= '0;
            rx_sr   <= '0;
            idx     <= '0;
            first_q <= 1'b0;
        end else if (!en) begin
            sclk    <= cpol;
            first_q <= 1'b0;
        end else begin
            unique case (state)
                SH_IDLE: begin
                    sclk <= cpol;
                    if (tx_take) begin
                        word_q  <= tx_word;
                        idx     <= len_m1;
                        rx_sr   <= '0;
                        first_q <= 1'b1;
                    end
                end
                SH_LEAD: if (tick) begin
                    sclk    <= ~sclk;
                    first_q <= 1'b0;
                    if (!cpha)         rx_sr <= {rx_sr[DATA_W-2:0], din};
                    else if (!first_q) idx   <= idx - 1'b1;
                end
                SH_TRAIL: if (tick) begin
                    sclk <= ~sclk;
                    if (cpha)             rx_sr <= {rx_sr[DATA_W-2:0], din};
                    else if (idx != '0)   idx   <= idx - 1'b1;
                end
                default: sclk <= cpol;
            endcase
        end
    end

endmodule

// File: rtl/ssp_master.sv
`timescale 1ns/1ps
module ssp_master
    import ssp_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int FIFO_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [4:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        half_tick,
    output logic [7:0]  rate_prescale,
    output logic [7:0]  rate_div,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic        irq_rx,
    output logic        irq_tx,
    output logic        irq_ror
);
    localparam int LEN_W = $clog2(DATA_W);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
    localparam int HALF  = FIFO_DEPTH / 2;

    logic [LEN_W-1:0] len_q;
    logic [7:0]       div_q, presc_q;
    logic             spo_q, sph_q;
    logic             rie_q, tie_q, rorie_q, lbm_q, sse_q, ms_q, sod_q;
    logic             ror_q;

    logic [2:0]        reg_idx;
    logic              wr_fmt, wr_ctl, wr_data, wr_presc, irq_clr, rd_data;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [CNT_W-1:0]  tx_count, rx_count;
    logic [DATA_W-1:0] tx_head, rx_head, rx_word;
    logic              tx_take, sh_done, sh_busy;

    assign reg_idx  = bus_addr[4:2];
    assign wr_fmt   = bus_en && bus_we && (reg_idx == ADR_FMT);
    assign wr_ctl   = bus_en && bus_we && (reg_idx == ADR_CTL);
    assign wr_data  = bus_en && bus_we && (reg_idx == ADR_DATA);
    assign wr_presc = bus_en && bus_we && (reg_idx == ADR_PRESC);
    assign irq_clr  = bus_en && bus_we && (reg_idx == ADR_IRQ);
    assign rd_data  = bus_en && !bus_we && (reg_idx == ADR_DATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0; div_q <= '0; presc_q <= '0;
            spo_q <= 1'b0; sph_q <= 1'b0;
            {sod_q, ms_q, sse_q, lbm_q, rorie_q, tie_q, rie_q} <= '0;
            ror_q <= 1'b0;
        end else begin
            if (wr_fmt) begin
                len_q <= bus_wdata[LEN_W-1:0];
                spo_q <= bus_wdata[6];
                sph_q <= bus_wdata[7];
                div_q <= bus_wdata[15:8];
            end
            if (wr_ctl)
                {sod_q, ms_q, sse_q, lbm_q, rorie_q, tie_q, rie_q} <= bus_wdata[6:0];
            if (wr_presc) presc_q <= bus_wdata[7:0];
            if (sh_done && rx_full) ror_q <= 1'b1;
            else if (irq_clr)       ror_q <= 1'b0;
        end
    end

    ssp_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) i_txq (
        .clk(clk), .rst_n(rst_n), .flush(!sse_q),
        .push(wr_data), .din(bus_wdata[DATA_W-1:0]), .pop(tx_take),
        .head(tx_head), .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    ssp_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) i_rxq (
        .clk(clk), .rst_n(rst_n), .flush(!sse_q),
        .push(sh_done), .din(rx_word), .pop(rd_data),
        .head(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    ssp_shifter #(.DATA_W(DATA_W)) i_shift (
        .clk(clk), .rst_n(rst_n), .en(sse_q), .tick(half_tick),
        .cpol(spo_q), .cpha(sph_q), .len_m1(len_q), .loop(lbm_q),
        .miso(miso), .tx_avail(!tx_empty), .tx_word(tx_head),
        .tx_take(tx_take), .sclk(sclk), .mosi(mosi),
        .rx_valid(sh_done), .rx_word(rx_word), .busy(sh_busy)
    );

    assign irq_rx        = rie_q && (rx_count >= CNT_W'(HALF));
    assign irq_tx        = tie_q && (tx_count <= CNT_W'(HALF));
    assign irq_ror       = rorie_q && ror_q;
    assign rate_prescale = presc_q;
    assign rate_div      = div_q;

    always_comb begin
        case (reg_idx)
            ADR_FMT:   bus_rdata = {div_q, sph_q, spo_q, 2'b00, 4'(len_q)};
            ADR_CTL:   bus_rdata = {9'd0, sod_q, ms_q, sse_q, lbm_q, rorie_q, tie_q, rie_q};
            ADR_DATA:  bus_rdata = rx_empty ? 16'd0 : 16'(rx_head);
            ADR_STAT:  bus_rdata = {11'd0, sh_busy || !tx_empty, rx_full, !rx_empty,
                                    !tx_full, tx_empty};
            ADR_PRESC: bus_rdata = {8'd0, presc_q};
            ADR_IRQ:   bus_rdata = {13'd0, irq_ror, irq_tx, irq_rx};
            default:   bus_rdata = 16'd0;
        endcase
    end

endmodule

// File: rtl/ssp_checker.sv
`timescale 1ns/1ps
module ssp_checker #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          cpol,
    input logic          tick,
    input logic          sh_busy,
    input logic          sclk,
    input logic [CW-1:0] tx_count,
    input logic [CW-1:0] rx_count,
    input logic          frame_done,
    input logic          rx_full,
    input logic          ror,
    input logic          clr_wr
);
    // R7
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH)));

    // R8
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && rx_full) |=> ror);

    // R9
    overrun_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !(frame_done && rx_full)) |=> !ror);

    // R11
    disabled_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && $past(!en)) |-> (tx_count == '0 && rx_count == '0 && !sh_busy));

    // R12
    sclk_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && $past(!en) && $stable(cpol)) |-> (sclk == cpol));

    // R12
    sclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_busy && en && !tick) |=> $stable(sclk));

endmodule

bind ssp_master ssp_checker #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .en(sse_q), .cpol(spo_q), .tick(half_tick),
    .sh_busy(sh_busy), .sclk(sclk), .tx_count(tx_count), .rx_count(rx_count),
    .frame_done(sh_done), .rx_full(rx_full), .ror(ror_q), .clr_wr(irq_clr)
);

// File: tb/test_ssp_master.sv
`timescale 1ns/1ps
module test_ssp_master;
    localparam logic [4:0] A_FMT = 5'h00, A_CTL = 5'h04, A_DATA = 5'h08,
                           A_STAT = 5'h0C, A_PRESC = 5'h10, A_IRQ = 5'h14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_en = 1'b0, bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0, bus_rdata;
    logic half_tick = 1'b0;
    logic [7:0] rate_prescale, rate_div;
    logic sclk, mosi, irq_rx, irq_tx, irq_ror;
    logic miso = 1'b0;

    int errs = 0, checks = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    ssp_master i_ssp_master (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .half_tick(half_tick), .rate_prescale(rate_prescale), .rate_div(rate_div),
        .sclk(sclk), .mosi(mosi), .miso(miso),
        .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_ror(irq_ror)
    );

    // tick source
    bit tick_run = 0;
    int tdiv = 1, tphase = 0;
    always @(negedge clk) begin
        tphase = (tphase + 1) % tdiv;
        half_tick <= tick_run && (tphase == 0);
    end

    // bench slave model
    bit mon_on = 0, cpha_b = 0, cpol_b = 0;
    int n_bits = 8, lcnt = 0, tcnt = 0, slv_ptr = 0, seen_n = 0;
    logic prev_sclk = 1'b0;
    logic [15:0] acc = '0;
    logic [15:0] slv_words [32];
    logic [15:0] mosi_seen [32];

    function automatic logic [15:0] fit(logic [15:0] w, int n);
        return w & 16'((32'd1 << n) - 1);
    endfunction

    always @(negedge clk) begin
        if (mon_on && sclk !== prev_sclk) begin
            if (sclk != cpol_b) begin
                acc = {acc[14:0], mosi};
                if (cpha_b) miso = slv_words[slv_ptr][n_bits-1-lcnt];
                lcnt++;
            end else begin
                tcnt++;
                if (tcnt == n_bits) begin
                    mosi_seen[seen_n] = fit(acc, n_bits);
                    seen_n++; slv_ptr++;
                    lcnt = 0; tcnt = 0; acc = '0;
                end else if (!cpha_b) begin
                    miso = slv_words[slv_ptr][n_bits-1-tcnt];
                end
            end
        end
        if (mon_on && lcnt == 0 && tcnt == 0 && !cpha_b)
            miso = slv_words[slv_ptr][n_bits-1];
        if (!mon_on) miso = 1'b0;
        prev_sclk = sclk;
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    task automatic bus_write(logic [4:0] a, logic [15:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
    endtask

    task automatic bus_read(logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 0;
    endtask

    // one burst of frames checked against the slave model
    task automatic run_xfer(int mode, int len, bit lp, int cnt, int td);
        logic [15:0] txw [8];
        logic [15:0] d, st;
        int guard;
        tick_run = 0;
        mon_on = 0;
        bus_write(A_CTL, 16'h0000);
        bus_write(A_FMT, (16'($urandom) & 16'hFF00) | 16'(((mode >> 1) & 1) << 6) |
                         16'((mode & 1) << 7) | 16'(len - 1));
        cpol_b = mode[1]; cpha_b = mode[0]; n_bits = len; tdiv = td;
        for (int i = 0; i < 32; i++) slv_words[i] = 16'($urandom);
        for (int i = 0; i < 8; i++) txw[i] = 16'($urandom);
        lcnt = 0; tcnt = 0; slv_ptr = 0; seen_n = 0; acc = '0;
        repeat (2) @(negedge clk);
        mon_on = 1;
        bus_write(A_CTL, lp ? 16'h0018 : 16'h0010);
        tick_run = 1;
        for (int i = 0; i < cnt; i++) bus_write(A_DATA, txw[i]);
        guard = 0;
        do begin
            bus_read(A_STAT, st);
            guard++;
        end while ((st[4] || seen_n < cnt) && guard < 3000);
        for (int i = 0; i < cnt; i++) begin
            bus_read(A_DATA, d);
            if (lp) chk("R5 loopback word", d, fit(txw[i], len));
            else    chk("R4 received word", d, fit(slv_words[i], len));
            chk("R3 mosi word", mosi_seen[i], fit(txw[i], len));
        end
        mon_on = 0;
        tick_run = 0;
    endtask

    initial begin
        #(20 * 150000);
        checks++; errs++;
        $display("FAIL watchdog R1 actual=running expected=done");
        summary();
    end

    initial begin
        logic [15:0] d;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        bus_read(A_STAT, d);
        chk("R1 status", d, 16'h0003);
        chk("R1 sclk", sclk, 0);
        chk("R1 mosi", mosi, 0);
        chk("R1 irqs", {irq_rx, irq_tx, irq_ror}, 0);

        // R2 register layout
        bus_write(A_FMT, 16'hA5FB);
        bus_read(A_FMT, d);
        chk("R2 format readback", d, 16'hA5CB);
        chk("R2 rate_div port", rate_div, 8'hA5);
        bus_write(A_PRESC, 16'h01FE);
        bus_read(A_PRESC, d);
        chk("R2 prescale readback", d, 16'h00FE);
        chk("R2 rate_prescale port", rate_prescale, 8'hFE);
        bus_write(A_CTL, 16'h006F);
        bus_read(A_CTL, d);
        chk("R2 control readback", d, 16'h006F);
        bus_write(A_CTL, 16'h0000);

        // R3 R4 directed modes and extreme lengths
        for (int m = 0; m < 4; m++) begin
            run_xfer(m, 16, 0, 3, 1);
            run_xfer(m, 4, 0, 3, 2);
        end
        // R5 loopback in two modes
        run_xfer(0, 8, 1, 4, 1);
        run_xfer(3, 13, 1, 4, 3);
        // constrained random bursts
        for (int k = 0; k < 14; k++)
            run_xfer(int'($urandom % 4), 4 + int'($urandom % 13),
                     ($urandom % 4) == 0, 1 + int'($urandom % 8), 1 + int'($urandom % 3));

        // R6 R7 R8 R9 R10: queue limits with loopback, tick stopped
        bus_write(A_CTL, 16'h0000);
        bus_write(A_FMT, 16'h0007);
        bus_write(A_CTL, 16'h001F);
        bus_read(A_STAT, d);
        chk("R6 status idle enabled", d, 16'h0003);
        chk("R10 tx irq with empty queue", irq_tx, 1);
        for (int i = 0; i < 4; i++) bus_write(A_DATA, 16'(8'h30 + i));
        chk("R10 tx irq at 4 queued", irq_tx, 1);
        bus_write(A_DATA, 16'h0034);
        chk("R10 tx irq at 5 queued", irq_tx, 0);
        for (int i = 5; i < 8; i++) bus_write(A_DATA, 16'(8'h30 + i));
        bus_read(A_STAT, d);
        chk("R6 status tx full", d, 16'h0010);
        bus_write(A_DATA, 16'h00AA);
        tick_run = 1; tdiv = 1;
        repeat (300) @(negedge clk);
        bus_read(A_STAT, d);
        chk("R6 status rx full", d, 16'h000F);
        chk("R10 rx irq at 8", irq_rx, 1);
        chk("R8 no overrun yet", irq_ror, 0);
        bus_write(A_DATA, 16'h0055);
        repeat (60) @(negedge clk);
        chk("R8 overrun irq", irq_ror, 1);
        bus_read(A_IRQ, d);
        chk("R8 irq register", d, 16'h0007);
        for (int i = 0; i < 8; i++) begin
            bus_read(A_DATA, d);
            chk("R7 R8 kept word", d, 16'(8'h30 + i));
            if (i == 3) chk("R10 rx irq at 4", irq_rx, 1);
            if (i == 4) chk("R10 rx irq at 3", irq_rx, 0);
        end
        bus_read(A_DATA, d);
        chk("R7 read of empty queue", d, 0);
        bus_write(A_IRQ, 16'h0000);
        chk("R9 overrun cleared", irq_ror, 0);
        bus_read(A_IRQ, d);
        chk("R9 irq register after clear", d, 16'h0002);
        tick_run = 0;

        // R11 R12 disable and clock rest level
        bus_write(A_CTL, 16'h0000);
        bus_write(A_FMT, 16'h0047);
        @(negedge clk);
        chk("R12 sclk rests high", sclk, 1);
        bus_write(A_CTL, 16'h0010);
        for (int i = 0; i < 3; i++) bus_write(A_DATA, 16'h0081);
        bus_read(A_STAT, d);
        chk("R6 busy with queued words", d, 16'h0012);
        bus_write(A_CTL, 16'h0000);
        bus_read(A_STAT, d);
        chk("R11 queues flushed", d, 16'h0003);
        bus_write(A_CTL, 16'h0010);
        bus_read(A_STAT, d);
        chk("R11 still empty after re-enable", d, 16'h0003);
        bus_write(A_DATA, 16'h00C3);
        tick_run = 1;
        repeat (5) @(negedge clk);
        tick_run = 0;
        repeat (2) @(negedge clk);
        d[0] = sclk;
        repeat (6) @(negedge clk);
        chk("R12 sclk holds without tick", sclk, d[0]);
        bus_write(A_CTL, 16'h0000);
        @(negedge clk);
        chk("R12 R11 sclk at rest after disable", sclk, 1);
        bus_read(A_STAT, d);
        chk("R11 idle after disable", d, 16'h0003);

        summary();
    end
endmodule